// File: doc/BRIEF.md
# Interrupt-Triggered Single-Unit DMA Engine

This block moves one data unit from a source address to a destination address each time an armed start source fires. It has 33 interrupt start inputs and one software start input, which gives 34 channels. Each channel keeps two 32-bit address registers, a 16-bit transfer counter and a mode word. A configuration write port loads these registers.

A trigger is first held as pending. When the engine is free, it serves the pending channel with the lowest index. It requests the bus and, once granted, runs a fixed five-state bus sequence. The sequence is two fetch states, a read of the source, a write of the destination and one more fetch state. The fetch states let the processor's instruction prefetch use the bus. When the instruction queue is full they are dummy states and the fetch strobe stays low.

After each unit the channel's addresses step and its counter decrements. When the counter reaches zero, a one-cycle done pulse is raised for that channel and the channel disarms itself. From then on the processor handles that interrupt in the usual way. A counter-only mode decrements the counter without touching the bus.

Top module: `irq_dma_engine`

## Requirements
- R1: Only the low 24 bits of the 32-bit address registers appear on `mem_addr`. A register loaded with 0xC3000040 writes to bus address 0x000040.
- R2: Mode bits [1:0] select the unit size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. The byte lane is the low two address bits aligned down to the size. The byte enables cover exactly that lane range. The read unit is taken from its source lanes and written to its destination lanes.
- R3: Mode bits [3:2] set the source step and bits [5:4] set the destination step. The codes are 1 for increment, 2 for decrement, and 0 or 3 for hold. Each step is by the unit size in bytes.
- R4: Every transfer decrements the counter. When the result is zero, `done[ch]` is high for exactly one cycle, beginning the cycle after the last sequence state. In that same cycle the channel's arm bit (mode bit 6) clears.
- R5: A counter loaded with 0 does not expire after one transfer. It stands for 65536 transfers.
- R6: Take the cycle in which a trigger is driven as cycle 0, with the grant held high and the engine idle. Then `bus_req` is high in cycles 2 to 7, the read is in cycle 5, the write is in cycle 6 and an expiring done is in cycle 8.
- R7: `fetch_en` is high in the two leading states and the trailing state of a sequence, 3 cycles per transfer, when `iq_full` is low. It stays low in all of them when `iq_full` is high, and the transfer still takes place.
- R8: `sw_req` starts the last channel, index 33.
- R9: Triggers that arrive while the engine is busy or waiting stay pending. They are then served lowest channel index first.
- R10: No read or write occurs while `bus_gnt` is low. `bus_req` stays high while the engine waits.
- R11: Size code 3 is counter-only mode. A trigger then uses no bus at all. The counter decrements, and at expiry done is high in cycle 3, counting the trigger cycle as cycle 0.
- R12: A trigger on a disarmed channel, whether it expired or was written with arm 0, starts no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 33 | Interrupt start pulses, one per channel 0..32 |
| sw_req | input | 1 | Software start pulse for channel 33 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 6 | Channel being configured |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 counter, 3 mode |
| cfg_wdata | input | 32 | Configuration write data |
| bus_req | output | 1 | Bus request held for the whole sequence |
| bus_gnt | input | 1 | Bus grant |
| iq_full | input | 1 | Instruction queue full; fetch states become dummy |
| fetch_en | output | 1 | Fetch slot offered to the prefetcher |
| mem_addr | output | 24 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled at the end of the read state |
| done | output | 34 | One-cycle expiry pulse per channel |

## Verification
With the grant high and the engine idle, a trigger driven in cycle 0 is registered as pending at the next edge. The bus is then requested in cycle 2, read in cycle 5 and written in cycle 6, and an expiring done shows in cycle 8. In counter-only mode the expiry done shows in cycle 3. A timing task drives a trigger and then counts falling edges to the first read, the first write, the done and the last request cycle, and it compares those counts with these numbers. Every other result is a bus write, and these are checked in order by a scoreboard. The expected write is queued before the trigger and popped at the falling edge on which `mem_wr` is seen. Lowest-index-first service therefore shows up as the order of the popped items. Effects that are meant to be absent, such as dummy fetches and ignored triggers, are checked by counting fetch and bus cycles across a settle window.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ARB, ST_FA, ST_FB, ST_RD, ST_WR, ST_FC, ST_TICK
   } seq_st_t;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_TICK = 2'd3
   } xsize_t;

   typedef enum logic [1:0] {
      STEP_KEEP     = 2'd0,
      STEP_UP       = 2'd1,
      STEP_DOWN     = 2'd2,
      STEP_KEEP_ALT = 2'd3
   } step_t;

   typedef struct packed {
      logic  arm;
      step_t dst_step;
      step_t src_step;
      xsize_t size;
   } chan_mode_t;

   localparam int MODE_W = $bits(chan_mode_t);

   typedef enum logic [1:0] {
      CFG_SRC  = 2'd0,
      CFG_DST  = 2'd1,
      CFG_CNT  = 2'd2,
      CFG_MODE = 2'd3
   } cfg_sel_t;

endpackage

// File: rtl/irq_dma_prio.sv
module irq_dma_prio #(
   parameter int N = 34,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   generate
      if (N == 1) begin : g_single
         assign any = req[0];
         assign idx = '0;
      end else begin : g_scan
         always_comb begin
            any = |req;
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = IW'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_dma_lane.sv
module irq_dma_lane
   import irq_dma_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTES  = DATA_W / 8,
   parameter int LB     = $clog2(BYTES),
   parameter int SH_W   = $clog2(DATA_W)
) (
   input  logic [LB-1:0]     lo,
   input  xsize_t            size,
   output logic [BYTES-1:0]  be,
   output logic [SH_W-1:0]   shift,
   output logic [DATA_W-1:0] mask
);

   logic [LB:0]   nb;
   logic [LB-1:0] lane;

   always_comb begin
      unique case (size)
         SZ_BYTE: nb = (LB+1)'(1);
         SZ_HALF: nb = (LB+1)'(2);
         default: nb = (LB+1)'(4);
      endcase
      lane = lo & ~LB'(nb - 1'b1);
   end

   generate
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
         assign be[b] = (b >= int'(lane)) && (b < int'(lane) + int'(nb));
         assign mask[b*8 +: 8] = {8{b < int'(nb)}};
      end
   endgenerate

   assign shift = {lane, 3'b000};

endmodule

// File: rtl/irq_dma_chregs.sv
module irq_dma_chregs
   import irq_dma_pkg::*;
#(
   parameter int NCH   = 34,
   parameter int REG_W = 32,
   parameter int CNT_W = 16,
   parameter int CH_W  = $clog2(NCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CH_W-1:0]  cfg_ch,
   input  cfg_sel_t         cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             upd_en,
   input  logic [CH_W-1:0]  upd_ch,
   input  logic [REG_W-1:0] upd_src,
   input  logic [REG_W-1:0] upd_dst,
   input  logic [CNT_W-1:0] upd_cnt,
   input  logic             upd_disarm,
   input  logic [CH_W-1:0]  a_ch,
   output logic [REG_W-1:0] a_src,
   output logic [REG_W-1:0] a_dst,
   output logic [CNT_W-1:0] a_cnt,
   output chan_mode_t       a_mode,
   input  logic [CH_W-1:0]  b_ch,
   output chan_mode_t       b_mode,
   output logic [NCH-1:0]   arm_vec
);

   logic [REG_W-1:0] src_r  [NCH];
   logic [REG_W-1:0] dst_r  [NCH];
   logic [CNT_W-1:0] cnt_r  [NCH];
   chan_mode_t       mode_r [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            src_r[c]  <= '0;
            dst_r[c]  <= '0;
            cnt_r[c]  <= '0;
            mode_r[c] <= '0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (upd_en && upd_ch == CH_W'(c)) begin
               src_r[c] <= upd_src;
               dst_r[c] <= upd_dst;
               cnt_r[c] <= upd_cnt;
               if (upd_disarm) mode_r[c].arm <= 1'b0;
            end
            if (cfg_we && cfg_ch == CH_W'(c)) begin
               unique case (cfg_sel)
                  CFG_SRC:  src_r[c]  <= cfg_wdata;
                  CFG_DST:  dst_r[c]  <= cfg_wdata;
                  CFG_CNT:  cnt_r[c]  <= cfg_wdata[CNT_W-1:0];
                  CFG_MODE: mode_r[c] <= chan_mode_t'(cfg_wdata[MODE_W-1:0]);
               endcase
            end
         end
      end
   end

   assign a_src  = src_r[a_ch];
   assign a_dst  = dst_r[a_ch];
   assign a_cnt  = cnt_r[a_ch];
   assign a_mode = mode_r[a_ch];
   assign b_mode = mode_r[b_ch];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_arm
         assign arm_vec[c] = mode_r[c].arm;
      end
   endgenerate

endmodule

// File: rtl/irq_dma_seq.sv
module irq_dma_seq
   import irq_dma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pick_any,
   input  logic pick_tick,
   input  logic bus_gnt,
   input  logic iq_full,
   output logic take,
   output logic bus_req,
   output logic fetch_en,
   output logic rd_en,
   output logic wr_en,
   output logic finish
);

   seq_st_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (pick_any) st_d = pick_tick ? ST_TICK : ST_ARB;
         ST_ARB:  if (bus_gnt) st_d = ST_FA;
         ST_FA:   st_d = ST_FB;
         ST_FB:   st_d = ST_RD;
         ST_RD:   st_d = ST_WR;
         ST_WR:   st_d = ST_FC;
         ST_FC:   st_d = ST_IDLE;
         ST_TICK: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign take     = (st_q == ST_IDLE) && pick_any;
   assign bus_req  = (st_q == ST_ARB) || (st_q == ST_FA) || (st_q == ST_FB) ||
                     (st_q == ST_RD)  || (st_q == ST_WR) || (st_q == ST_FC);
   assign fetch_en = ((st_q == ST_FA) || (st_q == ST_FB) || (st_q == ST_FC)) && !iq_full;
   assign rd_en    = (st_q == ST_RD);
   assign wr_en    = (st_q == ST_WR);
   assign finish   = (st_q == ST_FC) || (st_q == ST_TICK);

   // R10
   gnt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || wr_en) |-> bus_gnt);

   // R6
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> wr_en);

   // R11
   tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pick_tick) |=> !bus_req);

endmodule

// File: rtl/irq_dma_engine.sv
module irq_dma_engine
   import irq_dma_pkg::*;
#(
   parameter int NUM_IRQ = 33,
   parameter int ADDR_W  = 24,
   parameter int REG_W   = 32,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int NCH     = NUM_IRQ + 1,
   parameter int CH_W    = $clog2(NCH),
   parameter int BYTES   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic              sw_req,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [1:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   input  logic              iq_full,
   output logic              fetch_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [BYTES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [NCH-1:0]    done
);

   localparam int LB   = $clog2(BYTES);
   localparam int SH_W = $clog2(DATA_W);

   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("NUM_IRQ must be at least 1");
      end
      if (ADDR_W > REG_W) begin : g_bad_addr
         $error("ADDR_W cannot exceed REG_W");
      end
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data
         $error("DATA_W must be 32 or 64");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic [NCH-1:0]   trig, pend_q, pend_d, clr, ready;
   logic             pick_any, take, finish, rd_en, wr_en;
   logic [CH_W-1:0]  pick_idx, act_ch;
   logic [REG_W-1:0] a_src, a_dst, nxt_src, nxt_dst, unit_bytes;
   logic [CNT_W-1:0] a_cnt, nxt_cnt;
   chan_mode_t       a_mode, b_mode;
   logic [NCH-1:0]   arm_vec;
   logic             expire, tick_mode;
   logic [BYTES-1:0] s_be, d_be;
   logic [SH_W-1:0]  s_sh, d_sh;
   logic [DATA_W-1:0] s_mask, d_mask, hold_q;
   logic [NCH-1:0]   done_q;

   assign trig  = {sw_req, irq_req};
   assign ready = pend_q & arm_vec;

   irq_dma_prio #(.N(NCH), .IW(CH_W)) u_prio (
      .req (ready),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_comb begin
      clr = '0;
      if (take) clr[pick_idx] = 1'b1;
      pend_d = (pend_q | trig) & arm_vec & ~clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_ch <= '0;
      end else begin
         pend_q <= pend_d;
         if (take) act_ch <= pick_idx;
      end
   end

   irq_dma_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pick_any  (pick_any),
      .pick_tick (b_mode.size == SZ_TICK),
      .bus_gnt   (bus_gnt),
      .iq_full   (iq_full),
      .take      (take),
      .bus_req   (bus_req),
      .fetch_en  (fetch_en),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .finish    (finish)
   );

   function automatic logic [REG_W-1:0] stepped(input logic [REG_W-1:0] a,
                                                input step_t st,
                                                input logic [REG_W-1:0] d);
      unique case (st)
         STEP_UP:   return a + d;
         STEP_DOWN: return a - d;
         default:   return a;
      endcase
   endfunction

   always_comb begin
      tick_mode  = (a_mode.size == SZ_TICK);
      unit_bytes = REG_W'(1) << a_mode.size;
      nxt_src    = tick_mode ? a_src : stepped(a_src, a_mode.src_step, unit_bytes);
      nxt_dst    = tick_mode ? a_dst : stepped(a_dst, a_mode.dst_step, unit_bytes);
      nxt_cnt    = a_cnt - 1'b1;
      expire     = (nxt_cnt == '0);
   end

   irq_dma_chregs #(.NCH(NCH), .REG_W(REG_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_ch     (cfg_ch),
      .cfg_sel    (cfg_sel_t'(cfg_sel)),
      .cfg_wdata  (cfg_wdata),
      .upd_en     (finish),
      .upd_ch     (act_ch),
      .upd_src    (nxt_src),
      .upd_dst    (nxt_dst),
      .upd_cnt    (nxt_cnt),
      .upd_disarm (expire),
      .a_ch       (act_ch),
      .a_src      (a_src),
      .a_dst      (a_dst),
      .a_cnt      (a_cnt),
      .a_mode     (a_mode),
      .b_ch       (pick_idx),
      .b_mode     (b_mode),
      .arm_vec    (arm_vec)
   );

   irq_dma_lane #(.DATA_W(DATA_W)) u_src_lane (
      .lo    (a_src[LB-1:0]),
      .size  (a_mode.size),
      .be    (s_be),
      .shift (s_sh),
      .mask  (s_mask)
   );

   irq_dma_lane #(.DATA_W(DATA_W)) u_dst_lane (
      .lo    (a_dst[LB-1:0]),
      .size  (a_mode.size),
      .be    (d_be),
      .shift (d_sh),
      .mask  (d_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         done_q <= '0;
      end else begin
         if (rd_en) hold_q <= (mem_rdata >> s_sh) & s_mask;
         done_q <= (finish && expire) ? (NCH'(1) << act_ch) : '0;
      end
   end

   always_comb begin
      mem_addr  = '0;
      mem_be    = '0;
      mem_wdata = '0;
      if (rd_en) begin
         mem_addr = a_src[ADDR_W-1:0];
         mem_be   = s_be;
      end else if (wr_en) begin
         mem_addr  = a_dst[ADDR_W-1:0];
         mem_be    = d_be;
         mem_wdata = (hold_q & d_mask) << d_sh;
      end
   end

   assign mem_rd = rd_en;
   assign mem_wr = wr_en;
   assign done   = done_q;

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done));

   // R4
   done_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |-> ((done & arm_vec) == '0));

   // R4
   done_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |=> ((done & $past(done)) == '0));

   // R12
   no_idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> bus_req);

endmodule

// File: tb/irq_dma_engine_bench.sv
module irq_dma_engine_bench;

   localparam int NI  = 33;
   localparam int NCH = NI + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NI-1:0] irq_req = '0;
   logic        sw_req = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_ch = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        bus_req, fetch_en, mem_rd, mem_wr;
   logic        bus_gnt = 1'b1;
   logic        iq_full = 1'b0;
   logic [23:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata, mem_rdata;
   logic [NCH-1:0] done;

   always #4 clk = ~clk;

   irq_dma_engine u_irq_dma_engine (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_req(sw_req),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .iq_full(iq_full), .fetch_en(fetch_en),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
   );

   function automatic logic [31:0] word_at(input int i);
      return {8'(i ^ 8'h5A), 8'(i + 8'h11), 8'(~i), 8'(i * 3)};
   endfunction

   assign mem_rdata = mem_rd ? word_at(int'(mem_addr[7:2])) : 32'h0;

   typedef struct packed {
      logic [23:0] a;
      logic [3:0]  be;
      logic [31:0] d;
   } wr_item_t;

   wr_item_t exp_q[$];
   int total = 0;
   int bad = 0;
   int fetch_cnt = 0;
   int busy_cnt = 0;
   int done_cnt[NCH];
   logic [NCH-1:0] prev_done = '0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   initial for (int c = 0; c < NCH; c++) done_cnt[c] = 0;

   // monitor: pops the scoreboard on every write, tallies fetch/bus/done cycles
   always @(negedge clk) begin
      if (rst_n) begin
         if ((mem_rd || mem_wr) && !bus_gnt)
            chk(0, "R10", "access without grant", 1, 0);
         if (mem_wr) begin
            if (exp_q.size() == 0) begin
               chk(0, "R12", "unexpected write", longint'(mem_addr), 0);
            end else begin
               wr_item_t it;
               it = exp_q.pop_front();
               chk(mem_addr == it.a, "R1", "write address", longint'(mem_addr), longint'(it.a));
               chk(mem_be == it.be, "R2", "byte enables", longint'(mem_be), longint'(it.be));
               chk(mem_wdata == it.d, "R2", "write data", longint'(mem_wdata), longint'(it.d));
            end
         end
         if (fetch_en) fetch_cnt++;
         if (bus_req || mem_rd || mem_wr) busy_cnt++;
         for (int c = 0; c < NCH; c++) if (done[c]) done_cnt[c]++;
         if ((done & prev_done) != '0)
            chk(0, "R4", "done longer than one cycle", longint'(done), 0);
         prev_done = done;
      end
   end

   function automatic logic [31:0] mode_w(input int sz, input int ss, input int ds, input int arm);
      return 32'((arm << 6) | (ds << 4) | (ss << 2) | sz);
   endfunction

   task automatic cfg(input int ch, input int sel, input logic [31:0] v);
      cfg_we = 1'b1; cfg_ch = 6'(ch); cfg_sel = 2'(sel); cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] n, input logic [31:0] m);
      cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, n); cfg(ch, 3, m);
   endtask

   task automatic set_trig(input int ch, input logic v);
      if (ch == NI) sw_req = v;
      else irq_req[ch] = v;
   endtask

   task automatic fire(input int ch);
      set_trig(ch, 1'b1);
      @(negedge clk);
      set_trig(ch, 1'b0);
   endtask

   task automatic settle();
      repeat (12) @(negedge clk);
   endtask

   // expected write from the size/lane rules of R2
   task automatic push(input logic [31:0] s, input logic [31:0] d, input int sz);
      int nb, ls, ld;
      logic [31:0] m, v;
      wr_item_t it;
      nb = 1 << sz;
      ls = int'(s[1:0]) & ~(nb - 1);
      ld = int'(d[1:0]) & ~(nb - 1);
      m  = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (nb * 8)) - 32'd1);
      v  = (word_at(int'(s[7:2])) >> (ls * 8)) & m;
      it.a  = d[23:0];
      it.be = 4'(((1 << nb) - 1) << ld);
      it.d  = v << (ld * 8);
      exp_q.push_back(it);
   endtask

   task automatic measure(input int ch, output int rd_at, output int wr_at,
                          output int dn_at, output int req_last);
      rd_at = -1; wr_at = -1; dn_at = -1; req_last = -1;
      set_trig(ch, 1'b1);
      for (int n = 1; n <= 12; n++) begin
         @(negedge clk);
         if (n == 1) set_trig(ch, 1'b0);
         if (mem_rd && rd_at < 0) rd_at = n;
         if (mem_wr && wr_at < 0) wr_at = n;
         if (done[ch] && dn_at < 0) dn_at = n;
         if (bus_req) req_last = n;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         chk(0, "R6", "watchdog expired", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int b0, f0, rd_at, wr_at, dn_at, req_last;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_req == 1'b0, "R6", "reset bus_req", longint'(bus_req), 0);
      chk(done == '0, "R4", "reset done", longint'(done), 0);
      chk(!mem_rd && !mem_wr, "R10", "reset strobes", longint'({mem_rd, mem_wr}), 0);

      // R1 R3: word units, both addresses increment, upper bits dropped
      setup(0, 32'hAB00_0010, 32'hC300_0040, 3, mode_w(2, 1, 1, 1));
      push(32'h10, 32'h40, 2); fire(0); settle();
      push(32'h14, 32'h44, 2); fire(0); settle();
      chk(done_cnt[0] == 0, "R4", "no done before expiry", done_cnt[0], 0);

      // R2 R3 R4: bytes across lanes, source up, destination down, expires at 2
      setup(1, 32'h21, 32'h42, 2, mode_w(0, 1, 2, 1));
      push(32'h21, 32'h42, 0); fire(1); settle();
      push(32'h22, 32'h41, 0); fire(1); settle();
      chk(done_cnt[1] == 1, "R4", "expiry done pulse", done_cnt[1], 1);
      b0 = busy_cnt;
      fire(1); settle();
      chk(busy_cnt == b0, "R12", "expired channel ignored", busy_cnt - b0, 0);

      // R5 R2 R3: half units, source held, counter loaded with 0
      setup(2, 32'h06, 32'h50, 0, mode_w(1, 0, 1, 1));
      push(32'h06, 32'h50, 1); fire(2); settle();
      push(32'h06, 32'h52, 1); fire(2); settle();
      push(32'h06, 32'h54, 1); fire(2); settle();
      chk(done_cnt[2] == 0, "R5", "zero count did not expire", done_cnt[2], 0);

      // R9 R10: grant withheld while triggers stack up
      setup(3, 32'h00, 32'h60, 5, mode_w(2, 1, 1, 1));
      setup(4, 32'h04, 32'h64, 5, mode_w(2, 1, 1, 1));
      setup(5, 32'h08, 32'h68, 5, mode_w(2, 1, 1, 1));
      bus_gnt = 1'b0;
      push(32'h00, 32'h60, 2); push(32'h04, 32'h64, 2); push(32'h08, 32'h68, 2);
      fire(3); repeat (3) @(negedge clk);
      fire(5); repeat (2) @(negedge clk);
      fire(4); repeat (4) @(negedge clk);
      chk(bus_req == 1'b1, "R10", "request held while waiting", longint'(bus_req), 1);
      chk(exp_q.size() == 3, "R10", "no write before grant", exp_q.size(), 3);
      bus_gnt = 1'b1;
      repeat (30) @(negedge clk);
      chk(exp_q.size() == 0, "R9", "all pending served", exp_q.size(), 0);

      // R7: fetch slots live, then dummy
      f0 = fetch_cnt;
      push(32'h04, 32'h64, 2); fire(3); settle();
      chk(fetch_cnt - f0 == 3, "R7", "fetch cycles per transfer", fetch_cnt - f0, 3);
      iq_full = 1'b1;
      f0 = fetch_cnt;
      push(32'h08, 32'h68, 2); fire(3); settle();
      chk(fetch_cnt - f0 == 0, "R7", "dummy fetch slots", fetch_cnt - f0, 0);
      iq_full = 1'b0;

      // R6: cycle placement of one expiring transfer
      setup(7, 32'h0C, 32'h70, 1, mode_w(2, 2, 2, 1));
      push(32'h0C, 32'h70, 2);
      measure(7, rd_at, wr_at, dn_at, req_last);
      chk(rd_at == 5, "R6", "read cycle", rd_at, 5);
      chk(wr_at == 6, "R6", "write cycle", wr_at, 6);
      chk(dn_at == 8, "R6", "done cycle", dn_at, 8);
      chk(req_last == 7, "R6", "last request cycle", req_last, 7);
      settle();

      // R11: counter-only mode
      setup(8, 32'h00, 32'h80, 2, mode_w(3, 1, 1, 1));
      b0 = busy_cnt;
      fire(8); settle();
      chk(done_cnt[8] == 0, "R11", "first tick no done", done_cnt[8], 0);
      measure(8, rd_at, wr_at, dn_at, req_last);
      chk(dn_at == 3, "R11", "tick expiry done cycle", dn_at, 3);
      chk(busy_cnt == b0, "R11", "no bus use", busy_cnt - b0, 0);

      // R8 R12: software start channel, then disarmed by a mode write
      setup(NI, 32'h1C, 32'h90, 3, mode_w(2, 0, 0, 1));
      push(32'h1C, 32'h90, 2); fire(NI); settle();
      chk(exp_q.size() == 0, "R8", "software start transfer", exp_q.size(), 0);
      cfg(NI, 3, mode_w(2, 0, 0, 0));
      b0 = busy_cnt;
      fire(NI); settle();
      chk(busy_cnt == b0, "R12", "disarmed channel ignored", busy_cnt - b0, 0);

      chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule